// File: doc/BRIEF.md
# Pipelined Synchronous Static Memory with Lane Writes

This block is a single-clock static memory with a registered front end and a registered read output. On every rising edge with `acc_strobe` high, the block captures the address, the chip-select lines, the write controls and the write data together. In the next cycle it performs the access. A read places its word in an output register one clock after capture. A write commits its selected byte lanes to the array at that same edge. Because the write controls are sampled together with the address, the choice between read and write, and the choice of lanes, can be made as late as the capturing edge.

A word is `LANES` lanes of `LANE_W` bits each. By default that is four 9-bit lanes, and each lane holds eight data bits and one parity bit. Writes are controlled at three levels. An all-lanes write overrides everything else. Otherwise a lane-write enable opens the individual lane selects. An access cycle is treated as a read when no lane is selected for writing. The data bus is modelled as a separate input and output, plus an output-drive flag. The output drive is gated at once, without waiting for a clock, by an output-enable pin and by a sleep pin. Sleep also blocks new accesses and leaves the stored words untouched.

Top module: `pipe_sync_sram`

## Requirements
- R1: When `acc_strobe` is high and `sleep` is low at a rising edge, the address, selects, write controls and `wdata` are captured at that edge. Later changes on those inputs do not alter the access.
- R2: A read returns the stored word on `rdata`, with `rdata_en` high, after the second rising edge counted from the edge of capture. Between those two edges the output still shows its previous state.
- R3: When `wr_all_n` is low on an access, all lanes are written, whatever the values of `lane_wr_en_n` and `lane_sel_n`.
- R4: When `wr_all_n` is high and `lane_wr_en_n` is low, lane k (bits [9k+8:9k]) is written exactly when `lane_sel_n[k]` is low. A cycle with `lane_wr_en_n` high, or with no lane selected, is a read.
- R5: A strobed cycle with `chip_en_n` high, `sel_hi` low or `sel_lo_n` high is a deselect. It writes nothing, and it drops `rdata_en` one clock after capture, not earlier.
- R6: `out_en_n` high forces `rdata_en` low and `rdata` to zero at once, with no clock edge. Returning it low restores the held word.
- R7: `sleep` high forces `rdata_en` low and `rdata` to zero at once. Strobes seen during sleep are ignored, and the stored words and the held output are kept.
- R8: On a cycle without a strobe, the output register keeps its previous word and drive state.
- R9: A write access drops `rdata_en` one clock after capture.
- R10: After a synchronous reset (`rst_n` low), `rdata_en` is low and `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_strobe | input | 1 | Starts an access on this edge |
| chip_en_n | input | 1 | Chip enable, active low |
| sel_hi | input | 1 | Chip select, active high |
| sel_lo_n | input | 1 | Chip select, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| lane_wr_en_n | input | 1 | Lane-write enable, active low |
| lane_sel_n | input | LANES | Per-lane write select, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Power-down, active high, asynchronous on the output |
| rdata | output | LANES*LANE_W | Read data, zero when not driven |
| rdata_en | output | 1 | High while the block drives `rdata` |

## Verification
Read data, and the output drop caused by a write or a deselect, both become due at the second rising edge after the inputs are driven: one edge to capture and one to fill the output register. The bench drives each access on a falling edge and returns the strobe to idle at the next falling edge. It samples only after the second rising edge, and it also samples between the two edges to confirm that nothing has changed early. The output-enable and sleep results are due without any edge, so the bench checks them one time step after the pin toggles, while the clock is held.

// File: rtl/sram_pkg.sv
// Package: shared types for the pipelined static memory.
// Assumes: imported by every module of the memory.
package sram_pkg;

    // Kind of access held in the capture stage.
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_DESEL = 2'd3
    } acc_kind_e;

endpackage

// File: rtl/sram_wr_decode.sv
// Module: turns the three-level write controls into per-lane write strobes.
// Assumes: all controls active low; pure combinational, used ahead of the
// capture register so the lane choice can settle until the clock edge.
module sram_wr_decode #(
    parameter int LANES = 4
) (
    input  logic             wr_all_n,
    input  logic             lane_wr_en_n,
    input  logic [LANES-1:0] lane_sel_n,
    output logic [LANES-1:0] lane_we
);

    // Priority: all-lanes write, then enable-gated per-lane selects.
    always_comb begin
        if (!wr_all_n) begin
            lane_we = '1;
        end else if (!lane_wr_en_n) begin
            lane_we = ~lane_sel_n;
        end else begin
            lane_we = '0;
        end
    end

endmodule

// File: rtl/sram_capture.sv
// Module: input register stage; classifies and captures one access per edge.
// Assumes: sleep blocks capture; the captured kind lasts a single cycle.
module sram_capture
    import sram_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_strobe,
    input  logic              sleep,
    input  logic              chip_en_n,
    input  logic              sel_hi,
    input  logic              sel_lo_n,
    input  logic [LANES-1:0]  lane_we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output acc_kind_e         kind_q,
    output logic [LANES-1:0]  we_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [WORD_W-1:0] wdata_q
);

    logic      chip_on;
    acc_kind_e kind_d;

    // Decide the access kind from the pins seen at this edge.
    always_comb begin
        chip_on = !chip_en_n && sel_hi && !sel_lo_n;
        if (!acc_strobe || sleep) begin
            kind_d = ACC_IDLE;
        end else if (!chip_on) begin
            kind_d = ACC_DESEL;
        end else if (|lane_we) begin
            kind_d = ACC_WRITE;
        end else begin
            kind_d = ACC_READ;
        end
    end

    // Register the kind every edge, address and data only on a live access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= ACC_IDLE;
            we_q    <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            kind_q <= kind_d;
            if (kind_d != ACC_IDLE) begin
                we_q    <= lane_we;
                addr_q  <= addr;
                wdata_q <= wdata;
            end
        end
    end

    AST_SLEEP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (kind_q == ACC_IDLE)); // R7

    AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_strobe |=> (kind_q == ACC_IDLE)); // R8

endmodule

// File: rtl/sram_array.sv
// Module: storage array, one memory per lane, written per lane.
// Assumes: one access per cycle, so read and write never meet; the array
// holds no reset, contents are defined only after being written.
module sram_array #(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int WORD_W = LANES * LANE_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic [LANES-1:0]  we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Commit this lane when its strobe is set.
        always_ff @(posedge clk) begin
            if (we[l]) begin
                mem[addr] <= wdata[l*LANE_W +: LANE_W];
            end
        end

        assign rdata[l*LANE_W +: LANE_W] = mem[addr];
    end

endmodule

// File: rtl/pipe_sync_sram.sv
// Module: top of the pipelined static memory. Input stage, array, output
// register and the asynchronous output gating.
// Assumes: a single clock; out_en_n and sleep act without a clock on the
// output only; sleep also blocks new captures in sram_capture.
module pipe_sync_sram
    import sram_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_strobe,
    input  logic              chip_en_n,
    input  logic              sel_hi,
    input  logic              sel_lo_n,
    input  logic              wr_all_n,
    input  logic              lane_wr_en_n,
    input  logic [LANES-1:0]  lane_sel_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              out_en_n,
    input  logic              sleep,
    output logic [WORD_W-1:0] rdata,
    output logic              rdata_en
);

    logic [LANES-1:0]  lane_we;
    acc_kind_e         kind_q;
    logic [LANES-1:0]  we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] wdata_q;
    logic [LANES-1:0]  arr_we;
    logic [WORD_W-1:0] arr_rdata;
    logic [WORD_W-1:0] dout_q;
    logic              vld_q;
    logic              drive;

    sram_wr_decode #(.LANES(LANES)) u_dec (
        .wr_all_n     (wr_all_n),
        .lane_wr_en_n (lane_wr_en_n),
        .lane_sel_n   (lane_sel_n),
        .lane_we      (lane_we)
    );

    sram_capture #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_strobe (acc_strobe),
        .sleep      (sleep),
        .chip_en_n  (chip_en_n),
        .sel_hi     (sel_hi),
        .sel_lo_n   (sel_lo_n),
        .lane_we    (lane_we),
        .addr       (addr),
        .wdata      (wdata),
        .kind_q     (kind_q),
        .we_q       (we_q),
        .addr_q     (addr_q),
        .wdata_q    (wdata_q)
    );

    assign arr_we = (kind_q == ACC_WRITE) ? we_q : '0;

    sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
        .clk   (clk),
        .we    (arr_we),
        .addr  (addr_q),
        .wdata (wdata_q),
        .rdata (arr_rdata)
    );

    // Output pipeline register: load on read, drop on write or deselect, hold on idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            case (kind_q)
                ACC_READ: begin
                    dout_q <= arr_rdata;
                    vld_q  <= 1'b1;
                end
                ACC_WRITE, ACC_DESEL: vld_q <= 1'b0;
                default: ;
            endcase
        end
    end

    // Asynchronous gating of the output drive by enable and sleep.
    always_comb begin
        drive    = vld_q && !out_en_n && !sleep;
        rdata_en = drive;
        rdata    = drive ? dout_q : '0;
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !vld_q); // R10

    AST_DESEL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_q == ACC_DESEL) |=> !rdata_en); // R5

    AST_DESEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_q == ACC_DESEL) |-> (arr_we == '0)); // R5

    AST_WRITE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_q == ACC_WRITE) |=> !rdata_en); // R9

    AST_READ_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_q == ACC_READ) |=> vld_q); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_q == ACC_IDLE) |=> ($stable(vld_q) && $stable(dout_q))); // R8

    AST_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_strobe && !sleep && !chip_en_n && sel_hi && !sel_lo_n && !wr_all_n)
        |=> (kind_q == ACC_WRITE && we_q == '1)); // R3

    AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_strobe && !sleep) |=> (addr_q == $past(addr))); // R1

endmodule

// File: tb/sim_pipe_sync_sram.sv
`timescale 1ns/1ps
module sim_pipe_sync_sram;

    localparam int ADDR_W = 4;
    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;

    typedef struct packed {
        logic              strb;
        logic              ce_n;
        logic              s_hi;
        logic              s_lo_n;
        logic              gw_n;
        logic              bwe_n;
        logic [3:0]        bw_n;
        logic [3:0]        adr;
        logic [35:0]       din;
        logic              oe_n;
        logic              x_en;
        logic [35:0]       x_dat;
        logic [3:0]        req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1,0,1,0, 0,1,4'hF, 4'h3, 36'h123456789, 0, 0, 36'h0,         4'd3}, // R3 all-lane write
        '{1,0,1,0, 1,1,4'hF, 4'h3, 36'h0,         0, 1, 36'h123456789, 4'd2}, // R2 read back
        '{1,0,1,0, 1,0,4'hA, 4'h3, 36'hFFFFFFFFF, 0, 0, 36'h0,         4'd4}, // R4 lanes 0,2
        '{1,0,1,0, 1,1,4'hF, 4'h3, 36'h0,         0, 1, 36'h127FD67FF, 4'd4}, // R4
        '{1,0,1,0, 0,1,4'hF, 4'h5, 36'hABCDEF012, 0, 0, 36'h0,         4'd3}, // R3 enable off
        '{1,0,1,0, 1,1,4'hF, 4'h5, 36'h0,         0, 1, 36'hABCDEF012, 4'd3}, // R3
        '{1,0,1,0, 1,1,4'h0, 4'h5, 36'h0,         0, 1, 36'hABCDEF012, 4'd4}, // R4 selects without enable
        '{1,0,1,0, 1,0,4'hF, 4'h5, 36'h0,         0, 1, 36'hABCDEF012, 4'd4}, // R4 enable, no lane
        '{1,0,1,0, 0,0,4'hE, 4'h6, 36'h011112222, 0, 0, 36'h0,         4'd3}, // R3 overrides selects
        '{1,0,1,0, 1,1,4'hF, 4'h6, 36'h0,         0, 1, 36'h011112222, 4'd3}, // R3
        '{1,1,1,0, 0,1,4'hF, 4'h5, 36'h0,         0, 0, 36'h0,         4'd5}, // R5 write while off
        '{1,0,1,0, 1,1,4'hF, 4'h5, 36'h0,         0, 1, 36'hABCDEF012, 4'd5}, // R5 nothing written
        '{1,0,0,0, 1,1,4'hF, 4'h5, 36'h0,         0, 0, 36'h0,         4'd5}, // R5 sel_hi low
        '{1,0,1,1, 1,1,4'hF, 4'h5, 36'h0,         0, 0, 36'h0,         4'd5}, // R5 sel_lo_n high
        '{1,0,1,0, 1,1,4'hF, 4'h3, 36'h0,         1, 0, 36'h0,         4'd6}, // R6 output off
        '{1,0,1,0, 1,1,4'hF, 4'h3, 36'h0,         0, 1, 36'h127FD67FF, 4'd6}, // R6
        '{1,0,1,0, 1,0,4'h7, 4'h6, 36'h0,         0, 0, 36'h0,         4'd4}, // R4 lane 3 only
        '{1,0,1,0, 1,1,4'hF, 4'h6, 36'h0,         0, 1, 36'h001112222, 4'd4}  // R4
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              acc_strobe, chip_en_n, sel_hi, sel_lo_n;
    logic              wr_all_n, lane_wr_en_n, out_en_n, sleep;
    logic [LANES-1:0]  lane_sel_n;
    logic [ADDR_W-1:0] addr;
    logic [WORD_W-1:0] wdata;
    logic [WORD_W-1:0] rdata;
    logic              rdata_en;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    pipe_sync_sram #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u0 (
        .clk(clk), .rst_n(rst_n), .acc_strobe(acc_strobe), .chip_en_n(chip_en_n),
        .sel_hi(sel_hi), .sel_lo_n(sel_lo_n), .wr_all_n(wr_all_n),
        .lane_wr_en_n(lane_wr_en_n), .lane_sel_n(lane_sel_n), .addr(addr),
        .wdata(wdata), .out_en_n(out_en_n), .sleep(sleep),
        .rdata(rdata), .rdata_en(rdata_en)
    );

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic a_en, input logic e_en,
                         input logic [WORD_W-1:0] a_d, input logic [WORD_W-1:0] e_d);
        checks++;
        if (a_en !== e_en || a_d !== e_d) begin
            errors++;
            $display("FAIL %s en=%0b dat=%h expected en=%0b dat=%h", req, a_en, a_d, e_en, e_d);
        end
    endtask

    task automatic idle_pins();
        acc_strobe = 1'b0; chip_en_n = 1'b0; sel_hi = 1'b1; sel_lo_n = 1'b0;
        wr_all_n = 1'b1; lane_wr_en_n = 1'b1; lane_sel_n = '1;
        addr = '0; wdata = '0;
    endtask

    // Drive an access at a falling edge; leave the pins idle afterwards.
    task automatic access(input logic ce, input logic gw, input logic bwe,
                          input logic [3:0] bw, input logic [3:0] a, input logic [35:0] d);
        @(negedge clk);
        acc_strobe = 1'b1; chip_en_n = ce; sel_hi = 1'b1; sel_lo_n = 1'b0;
        wr_all_n = gw; lane_wr_en_n = bwe; lane_sel_n = bw; addr = a; wdata = d;
        @(posedge clk);
        #1;
        idle_pins();
    endtask

    initial begin
        rst_n = 1'b0; out_en_n = 1'b0; sleep = 1'b0;
        idle_pins();
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset", rdata_en, 1'b0, rdata, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: capture edge, result edge, sample at the falling edge after.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            acc_strobe = VECS[i].strb; chip_en_n = VECS[i].ce_n;
            sel_hi = VECS[i].s_hi; sel_lo_n = VECS[i].s_lo_n;
            wr_all_n = VECS[i].gw_n; lane_wr_en_n = VECS[i].bwe_n;
            lane_sel_n = VECS[i].bw_n; addr = VECS[i].adr; wdata = VECS[i].din;
            out_en_n = VECS[i].oe_n;
            @(negedge clk);
            idle_pins();
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VECS[i].req, i),
                  rdata_en, VECS[i].x_en, rdata, VECS[i].x_dat);
            out_en_n = 1'b0;
        end

        // R2 / R1: between capture and result the old word is still shown.
        access(1'b0, 1'b1, 1'b1, 4'hF, 4'h5, 36'h0);
        check("R2 before result edge", rdata_en, 1'b1, rdata, 36'h001112222);
        @(posedge clk);
        #1;
        check("R1 R2 read after second edge", rdata_en, 1'b1, rdata, 36'hABCDEF012);

        // R8: no strobe, output held over several edges.
        repeat (4) @(posedge clk);
        #1;
        check("R8 idle hold", rdata_en, 1'b1, rdata, 36'hABCDEF012);

        // R5: deselect drops the drive one clock after capture, not at capture.
        access(1'b1, 1'b1, 1'b1, 4'hF, 4'h5, 36'h0);
        check("R5 still driven at capture", rdata_en, 1'b1, rdata, 36'hABCDEF012);
        @(posedge clk);
        #1;
        check("R5 dropped one clock later", rdata_en, 1'b0, rdata, '0);

        // R9: a write drops the drive one clock after capture.
        access(1'b0, 1'b1, 1'b1, 4'hF, 4'h3, 36'h0);
        @(posedge clk);
        #1;
        access(1'b0, 1'b1, 1'b0, 4'hE, 4'h7, 36'h0000001AB);
        check("R9 driven at write capture", rdata_en, 1'b1, rdata, 36'h127FD67FF);
        @(posedge clk);
        #1;
        check("R9 dropped after write", rdata_en, 1'b0, rdata, '0);

        // R6: output enable acts with the clock held.
        access(1'b0, 1'b1, 1'b1, 4'hF, 4'h5, 36'h0);
        @(posedge clk);
        @(negedge clk);
        out_en_n = 1'b1;
        #0.5;
        check("R6 async off", rdata_en, 1'b0, rdata, '0);
        out_en_n = 1'b0;
        #0.5;
        check("R6 async on", rdata_en, 1'b1, rdata, 36'hABCDEF012);

        // R7: sleep gates at once and ignores a strobed write.
        sleep = 1'b1;
        #0.5;
        check("R7 async sleep", rdata_en, 1'b0, rdata, '0);
        @(negedge clk);
        acc_strobe = 1'b1; wr_all_n = 1'b0; addr = 4'h5; wdata = 36'h0;
        repeat (2) @(negedge clk);
        idle_pins();
        @(negedge clk);
        sleep = 1'b0;
        #0.5;
        check("R7 output kept after wake", rdata_en, 1'b1, rdata, 36'hABCDEF012);
        access(1'b0, 1'b1, 1'b1, 4'hF, 4'h5, 36'h0);
        @(posedge clk);
        #1;
        check("R7 contents kept", rdata_en, 1'b1, rdata, 36'hABCDEF012);

        // R4: the single-lane write at address 7 left only lane 0 defined.
        access(1'b0, 1'b1, 1'b1, 4'hF, 4'h7, 36'h0);
        @(posedge clk);
        #1;
        check("R4 lane 0 word", rdata_en, 1'b1, rdata & 36'h0000001FF, 36'h0000001AB);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule